// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the word address for each cycle of a burst-capable synchronous memory. In a start cycle it takes an external word address and records it as the burst base. On each following advance cycle it steps a two-bit beat counter. The low address bits it outputs follow either a wrapping linear count or an XOR-based interleaved pattern. The upper address bits stay fixed for the whole burst.

Each output cycle also carries three flags: a burst-active flag, a memory-operation strobe, and the read/write type. These feed the read/write pipeline of the memory.

An active-low clock enable freezes every register. A start request made while any chip select is inactive ends the current burst and does not accept the new address.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_ni` is low, `active_o`, `op_valid_o` and `op_wr_o` are 0 and `addr_o` is 0, and this takes effect without waiting for a clock edge.
- R2: A start cycle has `clk_en_ni`=0, `load_ni`=0 and every bit of `sel_i` equal to 1. After the edge that ends a start cycle:
  - `addr_o` equals the sampled `addr_i`;
  - `active_o`=1 and `op_valid_o`=1;
  - `op_wr_o` equals the sampled `wr_i` (1 = write).
- R3: When `interleave_i` was 0 at the start cycle, the low two bits of `addr_o` on successive advance cycles are start+1, start+2, start+3 (modulo 4), and bits 16..2 never change. An advance cycle has `clk_en_ni`=0, `load_ni`=1 and `active_o`=1.
- R4: When `interleave_i` was 1 at the start cycle, the low two bits on beat n (n = 0..3) equal the start low bits XOR n.
- R5: The advance that follows the fourth beat returns `addr_o` to the start address, in both orders.
- R6: On advance cycles `op_wr_o` keeps the value taken at the start cycle, whatever `wr_i` is.
- R7: While `clk_en_ni`=1 all outputs hold their values and every other input is ignored.
- R8: A cycle with `clk_en_ni`=0, `load_ni`=0 and any bit of `sel_i` at 0 clears `active_o` and `op_valid_o`. It leaves `addr_o` and `op_wr_o` unchanged and ignores `addr_i`.
- R9: An advance request (`load_ni`=1) while `active_o`=0 gives `op_valid_o`=0 and leaves `addr_o` unchanged.
- R10: The burst order is taken from `interleave_i` only at the start cycle. Its value during advance cycles has no effect.
- R11: A start cycle during an active burst restarts the burst at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high freezes the block |
| load_ni | input | 1 | 0 = start a burst at `addr_i`, 1 = advance |
| sel_i | input | NUM_SEL | Chip selects, all must be 1 to start |
| wr_i | input | 1 | Operation type at start, 1 = write |
| interleave_i | input | 1 | Burst order at start, 1 = interleaved |
| addr_i | input | ADDR_W | External word address |
| addr_o | output | ADDR_W | Array address of the current cycle |
| active_o | output | 1 | Burst in progress |
| op_valid_o | output | 1 | Memory operation this cycle |
| op_wr_o | output | 1 | Type of that operation, 1 = write |

## Verification
A deselecting start request and a clock-enable stall can be presented in the same cycle. The stall must win: the burst survives, and the next advance continues from the held beat. The bench provokes this by raising `clk_en_ni` while `load_ni` is low and one select bit is low. It judges the result by checking that the outputs are unchanged in that cycle and that the following advance lands on the wrapped linear address. A second overlap, a start cycle that arrives during a running burst, is judged by checking that the new base and operation type replace the old ones at once.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef struct packed {
    logic start;
    logic step;
    logic stop;
  } seq_cmd_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int NUM_SEL = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clk_en_ni,
  input  logic               load_ni,
  input  logic [NUM_SEL-1:0] sel_i,
  input  logic               wr_i,
  input  logic               interleave_i,
  output seq_cmd_t           cmd_o,
  output logic               active_o,
  output logic               op_valid_o,
  output logic               op_wr_o,
  output order_e             order_o
);
  logic selected;
  assign selected = &sel_i;

  always_comb begin
    cmd_o = '0;
    if (!clk_en_ni) begin
      if (!load_ni) begin
        cmd_o.start = selected;
        cmd_o.stop  = !selected;
      end else begin
        cmd_o.step  = active_o;  // idle advance is dropped
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o   <= 1'b0;
      op_valid_o <= 1'b0;
      op_wr_o    <= 1'b0;
      order_o    <= ORD_LINEAR;
    end else if (!clk_en_ni) begin
      if (cmd_o.start) begin
        active_o <= 1'b1;
        op_wr_o  <= wr_i;
        order_o  <= order_e'(interleave_i);
      end else if (cmd_o.stop) begin
        active_o <= 1'b0;
      end
      op_valid_o <= cmd_o.start | cmd_o.step;
    end
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_o <= '0;
    else if (start_i) beat_o <= '0;
    else if (step_i)  beat_o <= beat_o + 1'b1;  // natural wrap
  end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BEAT_W-1:0] low_lin, low_ilv, low_sel;

  assign low_lin = base_i[BEAT_W-1:0] + beat_i;
  assign low_ilv = base_i[BEAT_W-1:0] ^ beat_i;
  assign low_sel = (order_i == ORD_INTERLEAVE) ? low_ilv : low_lin;
  assign addr_o  = {base_i[ADDR_W-1:BEAT_W], low_sel};
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BURST_LEN = 4,
  parameter int NUM_SEL   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clk_en_ni,
  input  logic               load_ni,
  input  logic [NUM_SEL-1:0] sel_i,
  input  logic               wr_i,
  input  logic               interleave_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               active_o,
  output logic               op_valid_o,
  output logic               op_wr_o
);
  localparam int BEAT_W = $clog2(BURST_LEN);

  seq_cmd_t          cmd;
  order_e            order_q;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;

  burst_ctrl #(.NUM_SEL(NUM_SEL)) u_ctrl (
    .clk_i, .rst_ni, .clk_en_ni, .load_ni, .sel_i, .wr_i, .interleave_i,
    .cmd_o(cmd), .active_o, .op_valid_o, .op_wr_o, .order_o(order_q)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_beat (
    .clk_i, .rst_ni, .start_i(cmd.start), .step_i(cmd.step), .beat_o(beat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (cmd.start) base_q <= addr_i;
  end

  burst_addr_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_map (
    .base_i(base_q), .beat_i(beat_q), .order_i(order_q), .addr_o
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int BEAT_W  = 2,
  parameter int NUM_SEL = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clk_en_ni,
  input logic               load_ni,
  input logic [NUM_SEL-1:0] sel_i,
  input logic               wr_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [ADDR_W-1:0]  addr_o,
  input logic               active_o,
  input logic               op_valid_o,
  input logic               op_wr_o,
  input order_e             order_i
);
  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !load_ni && &sel_i) |=>
      (addr_o == $past(addr_i) && active_o && op_valid_o && op_wr_o == $past(wr_i)));

  assert_linear_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && load_ni && active_o && order_i == ORD_LINEAR) |=>
      (addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)));

  assert_advance_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && load_ni && active_o) |=>
      (op_valid_o && op_wr_o == $past(op_wr_o)
       && addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> ($stable(addr_o) && $stable(active_o)
                   && $stable(op_valid_o) && $stable(op_wr_o)));

  assert_deselect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !load_ni && !(&sel_i)) |=>
      (!active_o && !op_valid_o && $stable(addr_o) && $stable(op_wr_o)));

  assert_idle_advance_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && load_ni && !active_o) |=>
      (!active_o && !op_valid_o && $stable(addr_o)));

  assert_valid_in_burst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> active_o);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .NUM_SEL(NUM_SEL)
) i_chk (
  .clk_i, .rst_ni, .clk_en_ni, .load_ni, .sel_i, .wr_i, .addr_i,
  .addr_o, .active_o, .op_valid_o, .op_wr_o, .order_i(order_q)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;
  localparam int ADDR_W = 17;
  localparam int NUM_SEL = 3;

  typedef struct packed {
    logic              cen_n;
    logic              ld_n;
    logic [2:0]        sel;
    logic              wr;
    logic              ilv;
    logic [ADDR_W-1:0] addr;
    logic              e_act;
    logic              e_val;
    logic              e_wr;
    logic [ADDR_W-1:0] e_addr;
    logic [7:0]        req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // cen ld  sel  wr ilv addr      act val wr  exp_addr  req
    '{1'b0,1'b0,3'b111,1'b1,1'b0,17'h12345, 1'b1,1'b1,1'b1,17'h12345, 8'd2},  // R2
    '{1'b0,1'b1,3'b111,1'b0,1'b0,17'h00000, 1'b1,1'b1,1'b1,17'h12346, 8'd6},  // R3 R6
    '{1'b0,1'b1,3'b111,1'b0,1'b0,17'h00000, 1'b1,1'b1,1'b1,17'h12347, 8'd3},  // R3
    '{1'b0,1'b1,3'b111,1'b0,1'b0,17'h00000, 1'b1,1'b1,1'b1,17'h12344, 8'd3},  // R3 wrap
    '{1'b0,1'b1,3'b111,1'b0,1'b0,17'h00000, 1'b1,1'b1,1'b1,17'h12345, 8'd5},  // R5
    '{1'b1,1'b0,3'b000,1'b0,1'b1,17'h00000, 1'b1,1'b1,1'b1,17'h12345, 8'd7},  // R7
    '{1'b0,1'b0,3'b111,1'b0,1'b1,17'h0ABCE, 1'b1,1'b1,1'b0,17'h0ABCE, 8'd11}, // R11
    '{1'b0,1'b1,3'b111,1'b1,1'b0,17'h00000, 1'b1,1'b1,1'b0,17'h0ABCF, 8'd10}, // R4 R10
    '{1'b0,1'b1,3'b111,1'b1,1'b0,17'h00000, 1'b1,1'b1,1'b0,17'h0ABCC, 8'd4},  // R4
    '{1'b0,1'b1,3'b111,1'b1,1'b0,17'h00000, 1'b1,1'b1,1'b0,17'h0ABCD, 8'd4},  // R4
    '{1'b0,1'b1,3'b111,1'b1,1'b0,17'h00000, 1'b1,1'b1,1'b0,17'h0ABCE, 8'd5},  // R5
    '{1'b0,1'b0,3'b101,1'b1,1'b0,17'h1FFFF, 1'b0,1'b0,1'b0,17'h0ABCE, 8'd8},  // R8
    '{1'b0,1'b1,3'b111,1'b1,1'b0,17'h00000, 1'b0,1'b0,1'b0,17'h0ABCE, 8'd9},  // R9
    '{1'b0,1'b0,3'b111,1'b1,1'b0,17'h00003, 1'b1,1'b1,1'b1,17'h00003, 8'd2},  // R2
    '{1'b1,1'b0,3'b011,1'b0,1'b0,17'h00010, 1'b1,1'b1,1'b1,17'h00003, 8'd7},  // R7 vs R8
    '{1'b0,1'b1,3'b111,1'b0,1'b1,17'h00000, 1'b1,1'b1,1'b1,17'h00000, 8'd3}   // R3 after stall
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clk_en_n = 1'b0;
  logic              load_n = 1'b1;
  logic [NUM_SEL-1:0] sel = '0;
  logic              wr = 1'b0;
  logic              ilv = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [ADDR_W-1:0] addr_q;
  logic              act_q, val_q, wr_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_LEN(4), .NUM_SEL(NUM_SEL)) i_burst_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_ni(clk_en_n), .load_ni(load_n),
    .sel_i(sel), .wr_i(wr), .interleave_i(ilv), .addr_i(addr),
    .addr_o(addr_q), .active_o(act_q), .op_valid_o(val_q), .op_wr_o(wr_q)
  );

  task automatic check(input int req, input logic e_act, input logic e_val,
                       input logic e_wr, input logic [ADDR_W-1:0] e_addr);
    n_run++;
    if ({act_q, val_q, wr_q, addr_q} !== {e_act, e_val, e_wr, e_addr}) begin
      n_fail++;
      $display("FAIL R%0d: act/val/wr/addr got %b%b%b %h exp %b%b%b %h",
               req, act_q, val_q, wr_q, addr_q, e_act, e_val, e_wr, e_addr);
    end
  endtask

  task automatic drive(input logic cn, input logic ln, input logic [2:0] s,
                       input logic w, input logic il, input logic [ADDR_W-1:0] a);
    clk_en_n = cn; load_n = ln; sel = s; wr = w; ilv = il; addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 1'b0, 1'b0, '0);  // R1 in reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cen_n, VECS[i].ld_n, VECS[i].sel, VECS[i].wr,
            VECS[i].ilv, VECS[i].addr);
      check(int'(VECS[i].req), VECS[i].e_act, VECS[i].e_val,
            VECS[i].e_wr, VECS[i].e_addr);
    end
    // R3 boundary: top address, upper bits must not carry
    drive(1'b0, 1'b0, 3'b111, 1'b0, 1'b0, 17'h1FFFF);
    check(2, 1'b1, 1'b1, 1'b0, 17'h1FFFF);
    drive(1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 17'h00000);
    check(3, 1'b1, 1'b1, 1'b0, 17'h1FFFC);
    // R10 interleaved start at low bits 11, mode pin toggled afterwards
    drive(1'b0, 1'b0, 3'b111, 1'b1, 1'b1, 17'h00407);
    drive(1'b0, 1'b1, 3'b111, 1'b0, 1'b0, 17'h00000);
    check(10, 1'b1, 1'b1, 1'b1, 17'h00406);  // 11^01=10
    drive(1'b0, 1'b1, 3'b111, 1'b0, 1'b0, 17'h00000);
    check(4, 1'b1, 1'b1, 1'b1, 17'h00405);   // 11^10=01
    // R1 asynchronous reset mid-burst
    #1 rst_n = 1'b0;
    #0.5 check(1, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b1, 3'b111, 1'b0, 1'b0, 17'h00000);
    check(9, 1'b0, 1'b0, 1'b0, '0);  // R9 idle advance after reset
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule